// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Unit

This block holds the interrupt flags, the error flags and the two configuration words of a NAND-style flash controller. A host reaches it through a small register port: a write strobe, an address, write data and combinational read data. The block also owns the command register. A command write that it accepts is either forwarded to the command engine as a one-cycle issue pulse or handled in place. Unknown codes raise an error, and the two reset codes start a warm reset.

The command engine reports each finished operation with a one-cycle completion pulse. The pulse carries a kind (plain, erase, program, load) and a fail flag. The unit turns these into flag bits and drives a level interrupt output whose polarity comes from configuration word 1. New commands are refused until software acknowledges the previous completion by clearing the master interrupt flag. A cold reset comes from the synchronous active-low reset pin. A warm reset comes from an accepted reset command, and the two load different interrupt values.

Top module: `flash_irq_status_unit`

## Requirements
- R1: After a cold reset (rst_n low at a clock edge) the block reads as follows: configuration 1 = 0x40C0, configuration 2 = 0x0000, controller status = 0x0000, interrupt status = 0x8080, command = 0x0000. rdy_o is 1 and irq_o is 1. The register addresses are 0 command, 1 configuration 1, 2 configuration 2, 3 controller status (read-only) and 4 interrupt status; any other address reads 0.
- R2: A write to interrupt status replaces it with the old value ANDed with the written data, so a write can only clear bits.
- R3: When a write leaves interrupt bit 15 clear, the error bits 10 to 13 of controller status are cleared in the same cycle. When bit 15 stays set, the error bits are kept.
- R4: A command write while interrupt bit 15 is set is discarded: the command register keeps its value, no issue pulse is given and no flag changes.
- R5: An accepted command write of a known code other than a reset code stores the code and drives cmd_issue_o high for exactly one cycle, with cmd_code_o carrying the code. The known codes are 0x00, 0x13, 0x1A, 0x1B, 0x23, 0x2A, 0x2C, 0x30, 0x65, 0x71, 0x80, 0x94, 0x95 and 0xB0, plus the reset codes 0xF0 and 0xF3.
- R6: A completion pulse sets interrupt bit 15 and the bit for its kind. The kind is given on evt_kind_i: 0 plain (no extra bit), 1 erase (bit 5), 2 program (bit 6), 3 load (bit 7).
- R7: A completion pulse with evt_fail_i set also sets controller status bit 10 (command error) and the error bit for its kind: erase bit 11, program bit 12, load bit 13.
- R8: An accepted write of an unknown code is stored. It sets controller status bit 10 and interrupt bit 15, and it gives no issue pulse.
- R9: An accepted write of 0xF0 or 0xF3 performs a warm reset. This gives the R1 values, except that interrupt status becomes 0x8010.
- R10: irq_o equals interrupt bit 15 XOR the inverse of configuration-1 bit 6. It reflects a register write from the following cycle.
- R11: A read of configuration 1 returns the stored value with bits 4:0 forced to zero. Configuration 2 reads back all 16 written bits.
- R12: Each write to configuration 1 sets rdy_o to the written bit 7 from the next cycle.
- R13: When a completion pulse and an interrupt-status write fall in the same cycle, the AND is applied first and the completion bits are set on top. Bit 15 therefore ends set, and the error bits are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Combinational read data for reg_addr_i |
| evt_done_i | input | 1 | Completion pulse from the command engine |
| evt_kind_i | input | 2 | Completion kind: 0 plain, 1 erase, 2 program, 3 load |
| evt_fail_i | input | 1 | Completion ended in failure |
| cmd_issue_o | output | 1 | One-cycle pulse for an accepted known command |
| cmd_code_o | output | 16 | Stored command code |
| irq_o | output | 1 | Level interrupt with programmable polarity |
| rdy_o | output | 1 | Ready level |

## Verification
The bench aims at the command gate. It writes commands while the master flag is still set and checks that neither the issue pulse nor the stored code moves. A gate that looked at the wrong bit, or checked the flag after the write, would launch a second operation over an unacknowledged one.

It also separates the two acknowledge paths. Clearing a completion bit while keeping bit 15 must leave the error flags in place. Only clearing bit 15 may drop them, so a design tying the error clear to any interrupt write gets caught.

A completion pulse and an acknowledge are driven in the same cycle to catch a design that lets the write win and loses an event. Warm and cold reset values are compared to find a shared reset path, and the polarity bit is flipped both ways to find an inverted interrupt output.

// File: rtl/fis_pkg.sv
// Shared definitions for the flash interrupt/status unit.
// Assumes a 16-bit register file; bit positions are fixed by the register layout.
package fis_pkg;

    localparam int REG_W = 16;

    // Register addresses on the host port
    localparam logic [2:0] A_CMD  = 3'd0;
    localparam logic [2:0] A_CFG1 = 3'd1;
    localparam logic [2:0] A_CFG2 = 3'd2;
    localparam logic [2:0] A_STAT = 3'd3;
    localparam logic [2:0] A_INT  = 3'd4;

    // Interrupt status bit positions
    localparam int I_MASTER = 15;
    localparam int I_RESET  = 4;
    localparam int I_ERASE  = 5;
    localparam int I_PROG   = 6;
    localparam int I_LOAD   = 7;

    // Controller status bit positions
    localparam int S_CMD   = 10;
    localparam int S_ERASE = 11;
    localparam int S_PROG  = 12;
    localparam int S_LOAD  = 13;

    localparam logic [REG_W-1:0] ERR_MASK =
        (16'h1 << S_CMD) | (16'h1 << S_ERASE) | (16'h1 << S_PROG) | (16'h1 << S_LOAD);

    // Reset values
    localparam logic [REG_W-1:0] CFG1_RST     = 16'h40C0;
    localparam logic [REG_W-1:0] CFG2_RST     = 16'h0000;
    localparam logic [REG_W-1:0] INT_COLD_RST = 16'h8080;
    localparam logic [REG_W-1:0] INT_WARM_RST = 16'h8010;

    // Configuration 1 bit positions
    localparam int C_IRQ_POL = 6;
    localparam int C_RDY     = 7;
    localparam int C_RD_MASK_BITS = 5;

    typedef enum logic [1:0] {
        EV_PLAIN = 2'd0,
        EV_ERASE = 2'd1,
        EV_PROG  = 2'd2,
        EV_LOAD  = 2'd3
    } evt_kind_e;

    typedef enum logic [1:0] {
        CC_UNKNOWN = 2'd0,
        CC_NORMAL  = 2'd1,
        CC_RESET   = 2'd2
    } cmd_class_e;

    // Classifies a command code written by the host
    function automatic cmd_class_e classify(input logic [REG_W-1:0] code);
        cmd_class_e c;
        if (code[REG_W-1:8] != '0) begin
            c = CC_UNKNOWN;
        end else begin
            case (code[7:0])
                8'hF0, 8'hF3: c = CC_RESET;
                8'h00, 8'h13, 8'h1A, 8'h1B, 8'h23, 8'h2A, 8'h2C,
                8'h30, 8'h65, 8'h71, 8'h80, 8'h94, 8'h95, 8'hB0: c = CC_NORMAL;
                default: c = CC_UNKNOWN;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/fis_cmd_gate.sv
// Command gate: accepts host command writes only while the master interrupt
// flag is clear, classifies the code, and produces the issue pulse, the
// unknown-command flag and the warm-reset request.
// Assumes the master flag input is the registered interrupt bit 15.
module fis_cmd_gate
    import fis_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_cmd_i,
    input  logic [W-1:0] wdata_i,
    input  logic         master_i,
    output logic         soft_rst_o,
    output logic         unknown_o,
    output logic         issue_o,
    output logic [W-1:0] code_o
);

    logic       accept;
    cmd_class_e cls;
    logic [W-1:0] code_q;
    logic         issue_q;

    // Decide acceptance and class of the current write
    always_comb begin
        accept     = we_cmd_i && !master_i;
        cls        = classify(wdata_i);
        soft_rst_o = accept && (cls == CC_RESET);
        unknown_o  = accept && (cls == CC_UNKNOWN);
    end

    // Hold the last accepted code and register the issue pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            issue_q <= 1'b0;
        end else if (soft_rst_o) begin
            code_q  <= '0;
            issue_q <= 1'b0;
        end else begin
            issue_q <= accept && (cls == CC_NORMAL);
            if (accept) code_q <= wdata_i;
        end
    end

    assign issue_o = issue_q;
    assign code_o  = code_q;

    assert_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_cmd_i && master_i) |=> (!issue_o && $stable(code_o)));

    assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |=> !issue_o);

endmodule

// File: rtl/fis_int_status.sv
// Interrupt and controller status registers. Host writes AND into the
// interrupt register; completion events and unknown commands set bits on top.
// Clearing the master bit clears the four error flags.
// Assumes at most one completion pulse per cycle.
module fis_int_status
    import fis_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst_i,
    input  logic         we_int_i,
    input  logic [W-1:0] wdata_i,
    input  logic         unknown_i,
    input  logic         evt_done_i,
    input  logic [1:0]   evt_kind_i,
    input  logic         evt_fail_i,
    output logic [W-1:0] int_o,
    output logic [W-1:0] stat_o
);

    logic [W-1:0] int_q, stat_q;
    logic [W-1:0] evt_int, evt_err;
    logic [W-1:0] int_and, int_nxt, stat_nxt;

    // Translate a completion pulse and an unknown command into set masks
    always_comb begin
        evt_int = '0;
        evt_err = '0;
        if (evt_done_i) begin
            evt_int[I_MASTER] = 1'b1;
            case (evt_kind_e'(evt_kind_i))
                EV_ERASE: evt_int[I_ERASE] = 1'b1;
                EV_PROG:  evt_int[I_PROG]  = 1'b1;
                EV_LOAD:  evt_int[I_LOAD]  = 1'b1;
                default:  ;
            endcase
            if (evt_fail_i) begin
                evt_err[S_CMD] = 1'b1;
                case (evt_kind_e'(evt_kind_i))
                    EV_ERASE: evt_err[S_ERASE] = 1'b1;
                    EV_PROG:  evt_err[S_PROG]  = 1'b1;
                    EV_LOAD:  evt_err[S_LOAD]  = 1'b1;
                    default:  ;
                endcase
            end
        end
        if (unknown_i) begin
            evt_int[I_MASTER] = 1'b1;
            evt_err[S_CMD]    = 1'b1;
        end
    end

    // Apply the host AND-write first, then OR in the new flags
    always_comb begin
        int_and  = we_int_i ? (int_q & wdata_i) : int_q;
        int_nxt  = int_and | evt_int;
        stat_nxt = (int_nxt[I_MASTER] ? stat_q : (stat_q & ~ERR_MASK)) | evt_err;
    end

    // Status register update with cold and warm reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q  <= INT_COLD_RST;
            stat_q <= '0;
        end else if (soft_rst_i) begin
            int_q  <= INT_WARM_RST;
            stat_q <= '0;
        end else begin
            int_q  <= int_nxt;
            stat_q <= stat_nxt;
        end
    end

    assign int_o  = int_q;
    assign stat_o = stat_q;

    assert_and_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_int_i && !evt_done_i && !unknown_i && !soft_rst_i)
        |=> (int_q == ($past(int_q) & $past(wdata_i))));

    assert_err_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_int_i && !wdata_i[I_MASTER] && !evt_done_i && !unknown_i && !soft_rst_i)
        |=> ((stat_q & ERR_MASK) == '0));

    assert_evt_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done_i && !soft_rst_i) |=> int_q[I_MASTER]);

    assert_fail_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done_i && evt_fail_i && !soft_rst_i) |=> stat_q[S_CMD]);

    assert_warm_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (int_q == INT_WARM_RST && stat_q == '0));

endmodule

// File: rtl/fis_config.sv
// System configuration words, ready level and interrupt polarity.
// Assumes writes arrive as single-cycle strobes from the top decode.
module fis_config
    import fis_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst_i,
    input  logic         we_cfg1_i,
    input  logic         we_cfg2_i,
    input  logic [W-1:0] wdata_i,
    input  logic         master_i,
    output logic [W-1:0] cfg1_rd_o,
    output logic [W-1:0] cfg2_o,
    output logic         rdy_o,
    output logic         irq_o
);

    logic [W-1:0] cfg1_q, cfg2_q;
    logic         rdy_q;

    // Configuration registers and ready level
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i) begin
            cfg1_q <= CFG1_RST;
            cfg2_q <= CFG2_RST;
            rdy_q  <= 1'b1;
        end else begin
            if (we_cfg1_i) begin
                cfg1_q <= wdata_i;
                rdy_q  <= wdata_i[C_RDY];
            end
            if (we_cfg2_i) cfg2_q <= wdata_i;
        end
    end

    // Read view of configuration 1 hides the low bits
    always_comb begin
        cfg1_rd_o = cfg1_q;
        cfg1_rd_o[C_RD_MASK_BITS-1:0] = '0;
    end

    assign cfg2_o = cfg2_q;
    assign rdy_o  = rdy_q;
    assign irq_o  = master_i ^ ~cfg1_q[C_IRQ_POL];

    assert_rdy_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (we_cfg1_i && !soft_rst_i) |=> (rdy_o == $past(wdata_i[C_RDY])));

    assert_cfg2_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_cfg2_i && !soft_rst_i) |=> $stable(cfg2_o));

endmodule

// File: rtl/flash_irq_status_unit.sv
// Top of the flash interrupt/status unit: decodes the host register port,
// wires the command gate, status registers and configuration block, and
// muxes read data. Assumes one register access per cycle.
module flash_irq_status_unit
    import fis_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              evt_done_i,
    input  logic [1:0]        evt_kind_i,
    input  logic              evt_fail_i,
    output logic              cmd_issue_o,
    output logic [DATA_W-1:0] cmd_code_o,
    output logic              irq_o,
    output logic              rdy_o
);

    logic we_cmd, we_cfg1, we_cfg2, we_int;
    logic soft_rst, unknown;
    logic [DATA_W-1:0] int_q, stat_q, cfg1_rd, cfg2_q;

    // Write strobe decode
    always_comb begin
        we_cmd  = reg_we_i && (reg_addr_i == ADDR_W'(A_CMD));
        we_cfg1 = reg_we_i && (reg_addr_i == ADDR_W'(A_CFG1));
        we_cfg2 = reg_we_i && (reg_addr_i == ADDR_W'(A_CFG2));
        we_int  = reg_we_i && (reg_addr_i == ADDR_W'(A_INT));
    end

    fis_cmd_gate #(.W(DATA_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_cmd_i   (we_cmd),
        .wdata_i    (reg_wdata_i),
        .master_i   (int_q[I_MASTER]),
        .soft_rst_o (soft_rst),
        .unknown_o  (unknown),
        .issue_o    (cmd_issue_o),
        .code_o     (cmd_code_o)
    );

    fis_int_status #(.W(DATA_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst),
        .we_int_i   (we_int),
        .wdata_i    (reg_wdata_i),
        .unknown_i  (unknown),
        .evt_done_i (evt_done_i),
        .evt_kind_i (evt_kind_i),
        .evt_fail_i (evt_fail_i),
        .int_o      (int_q),
        .stat_o     (stat_q)
    );

    fis_config #(.W(DATA_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_i (soft_rst),
        .we_cfg1_i  (we_cfg1),
        .we_cfg2_i  (we_cfg2),
        .wdata_i    (reg_wdata_i),
        .master_i   (int_q[I_MASTER]),
        .cfg1_rd_o  (cfg1_rd),
        .cfg2_o     (cfg2_q),
        .rdy_o      (rdy_o),
        .irq_o      (irq_o)
    );

    // Read data mux
    always_comb begin
        case (reg_addr_i)
            ADDR_W'(A_CMD):  reg_rdata_o = cmd_code_o;
            ADDR_W'(A_CFG1): reg_rdata_o = cfg1_rd;
            ADDR_W'(A_CFG2): reg_rdata_o = cfg2_q;
            ADDR_W'(A_STAT): reg_rdata_o = stat_q;
            ADDR_W'(A_INT):  reg_rdata_o = int_q;
            default:         reg_rdata_o = '0;
        endcase
    end

    assert_irq_master_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done_i && !soft_rst && !we_cfg1) |=> (irq_o == reg_rdata_cfg_pol()));

    // Expected interrupt level for an asserted master flag
    function automatic logic reg_rdata_cfg_pol();
        return cfg1_rd[C_IRQ_POL];
    endfunction

endmodule

// File: tb/flash_irq_status_unit_bench.sv
module flash_irq_status_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        evt_done = 1'b0;
    logic [1:0]  evt_kind = 2'd0;
    logic        evt_fail = 1'b0;
    logic        cmd_issue;
    logic [15:0] cmd_code;
    logic        irq, rdy;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic last_issue;

    always #4 clk = ~clk;

    flash_irq_status_unit u_flash_irq_status_unit (
        .clk(clk), .rst_n(rst_n),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .evt_done_i(evt_done), .evt_kind_i(evt_kind), .evt_fail_i(evt_fail),
        .cmd_issue_o(cmd_issue), .cmd_code_o(cmd_code),
        .irq_o(irq), .rdy_o(rdy)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // Write one register; records the issue pulse seen after the edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        last_issue = cmd_issue;
        reg_we = 1'b0;
    endtask

    task automatic evt(input logic [1:0] k, input logic f);
        @(negedge clk);
        evt_done = 1'b1; evt_kind = k; evt_fail = f;
        @(negedge clk);
        evt_done = 1'b0; evt_fail = 1'b0;
    endtask

    task automatic cold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_values();
        cold_reset();
        chk_reg("R1 cfg1", 3'd1, 16'h40C0);
        chk_reg("R1 cfg2", 3'd2, 16'h0000);
        chk_reg("R1 status", 3'd3, 16'h0000);
        chk_reg("R1 int", 3'd4, 16'h8080);
        chk_reg("R1 cmd", 3'd0, 16'h0000);
        chk_reg("R1 unmapped", 3'd6, 16'h0000);
        chk("R1 rdy", {15'd0, rdy}, 16'd1);
        chk("R1 irq", {15'd0, irq}, 16'd1);
    endtask

    task automatic t_blocked_cmd();
        wr(3'd0, 16'h0094);
        chk("R4 no issue", {15'd0, last_issue}, 16'd0);
        chk_reg("R4 cmd kept", 3'd0, 16'h0000);
        chk_reg("R4 int kept", 3'd4, 16'h8080);
    endtask

    task automatic t_and_write();
        wr(3'd4, 16'hFF7F);
        chk_reg("R2 and keeps master", 3'd4, 16'h8000);
        chk("R10 irq master set", {15'd0, irq}, 16'd1);
        wr(3'd4, 16'h7FFF);
        chk_reg("R2 and clears master", 3'd4, 16'h0000);
        chk("R10 irq master clear", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_issue();
        wr(3'd0, 16'h0080);
        chk("R5 issue pulse", {15'd0, last_issue}, 16'd1);
        chk("R5 code out", cmd_code, 16'h0080);
        @(negedge clk);
        chk("R5 pulse one cycle", {15'd0, cmd_issue}, 16'd0);
        chk_reg("R5 cmd read", 3'd0, 16'h0080);
    endtask

    task automatic t_events();
        evt(2'd2, 1'b0);
        chk_reg("R6 program done", 3'd4, 16'h8040);
        chk("R10 irq on event", {15'd0, irq}, 16'd1);
        wr(3'd0, 16'h0013);
        chk("R4 blocked after event", {15'd0, last_issue}, 16'd0);
        chk_reg("R4 code kept", 3'd0, 16'h0080);
        evt(2'd1, 1'b1);
        chk_reg("R6 erase bit", 3'd4, 16'h8060);
        chk_reg("R7 erase fail", 3'd3, 16'h0C00);
        wr(3'd4, 16'hFFDF);
        chk_reg("R3 errors kept", 3'd3, 16'h0C00);
        chk_reg("R2 partial clear", 3'd4, 16'h8040);
        wr(3'd4, 16'h0000);
        chk_reg("R3 errors cleared", 3'd3, 16'h0000);
        chk_reg("R3 int cleared", 3'd4, 16'h0000);
        evt(2'd3, 1'b1);
        chk_reg("R7 load fail", 3'd3, 16'h2400);
        chk_reg("R6 load bit", 3'd4, 16'h8080);
        wr(3'd4, 16'h0000);
        evt(2'd0, 1'b0);
        chk_reg("R6 plain", 3'd4, 16'h8000);
        wr(3'd4, 16'h0000);
    endtask

    task automatic t_unknown();
        wr(3'd0, 16'h0042);
        chk("R8 no issue", {15'd0, last_issue}, 16'd0);
        chk_reg("R8 status", 3'd3, 16'h0400);
        chk_reg("R8 int", 3'd4, 16'h8000);
        chk_reg("R8 code stored", 3'd0, 16'h0042);
        wr(3'd4, 16'h0000);
    endtask

    task automatic t_collision();
        evt(2'd2, 1'b1);
        chk_reg("R7 program fail", 3'd3, 16'h1400);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 16'h0000;
        evt_done = 1'b1; evt_kind = 2'd3; evt_fail = 1'b0;
        @(negedge clk);
        reg_we = 1'b0; evt_done = 1'b0;
        chk_reg("R13 event wins", 3'd4, 16'h8080);
        chk_reg("R13 errors kept", 3'd3, 16'h1400);
    endtask

    task automatic t_config();
        wr(3'd1, 16'h001F);
        chk_reg("R11 cfg1 mask", 3'd1, 16'h0000);
        chk("R12 rdy low", {15'd0, rdy}, 16'd0);
        chk("R10 inverted polarity set", {15'd0, irq}, 16'd0);
        wr(3'd4, 16'h0000);
        chk("R10 inverted polarity clear", {15'd0, irq}, 16'd1);
        wr(3'd2, 16'hABCD);
        chk_reg("R11 cfg2 full", 3'd2, 16'hABCD);
        wr(3'd1, 16'h00DF);
        chk_reg("R11 cfg1 mask high", 3'd1, 16'h00C0);
        chk("R12 rdy high", {15'd0, rdy}, 16'd1);
        chk("R10 normal polarity clear", {15'd0, irq}, 16'd0);
    endtask

    task automatic t_warm();
        wr(3'd1, 16'h0000);
        wr(3'd2, 16'h1234);
        wr(3'd0, 16'h00F3);
        chk("R9 no issue", {15'd0, last_issue}, 16'd0);
        chk_reg("R9 int", 3'd4, 16'h8010);
        chk_reg("R9 cfg1", 3'd1, 16'h40C0);
        chk_reg("R9 cfg2", 3'd2, 16'h0000);
        chk_reg("R9 status", 3'd3, 16'h0000);
        chk_reg("R9 cmd", 3'd0, 16'h0000);
        chk("R9 rdy", {15'd0, rdy}, 16'd1);
        wr(3'd4, 16'h0000);
        wr(3'd0, 16'h00F0);
        chk_reg("R9 second reset code", 3'd4, 16'h8010);
        wr(3'd4, 16'h0000);
        cold_reset();
        chk_reg("R1 cold after use", 3'd4, 16'h8080);
    endtask

    initial begin
        last_issue = 1'b0;
        t_reset_values();
        t_blocked_cmd();
        t_and_write();
        t_issue();
        t_events();
        t_unknown();
        t_collision();
        t_config();
        t_warm();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule